// File: doc/BRIEF.md
# Password-Protected Watchdog Reset Controller

This block is a countdown watchdog that can pull the whole chip into reset. Software reaches it through a 32-bit read/write strobe interface. It exposes two registers: a tick counter and a reset-control word. A write changes a register only when its top byte carries the key value 0x5A. A write with any other top byte is dropped, so a runaway program that scribbles over the address space is unlikely to disarm or retune the timer.

To arm the timer, software loads a tick count and then writes the reset-control word with its two-bit configuration field set to "full reset". A free-running prescaler divides the system clock down to a 65536 Hz tick. While the timer is armed, each tick takes one from the count. When the count runs out, the block raises a single-cycle chip-reset request and returns to the disarmed state. Software keeps the system alive by reloading the count before it expires. It stops the timer by writing the key together with the value 0x102 to the reset-control word. A millisecond timeout converts to ticks as (ms << 16) / 1000. The 20-bit count therefore allows just under 16 seconds, and 10 ticks is roughly 150 µs.

Top module: `wdg_reset_ctrl`

## Requirements
- R1: The reset-control word is at address 0x1C and the tick counter is at address 0x24. A write to any other address changes nothing, even with the key. A read of any other address returns 0.
- R2: A write is accepted only when wdata[31:24] equals 0x5A. Otherwise neither register changes, and a running countdown carries on.
- R3: An accepted write to 0x24 loads wdata[19:0] into the counter and ignores bits 23:20. A read of 0x24 returns the counter zero-extended to 32 bits.
- R4: An accepted write to 0x1C stores wdata[23:0]. Bits 5:4 form the configuration field. The timer is armed only while that field is 2'b10. With 00, 01 or 11 in the field, the counter does not change.
- R5: While the timer is armed, each tick takes one from the counter. On a tick that finds the counter at 1 or 0, the counter becomes 0 and bits 5:4 become 00, with the other control bits kept. In that case reset_req is high for exactly one cycle, starting on the clock edge that follows the edge where the tick was taken.
- R6: An accepted write of 0x102 to 0x1C disarms the timer. After that, the counter stays frozen and no reset request follows.
- R7: An accepted write to 0x24 while the timer is armed restarts the countdown from the new value. Reloading the counter at regular intervals keeps reset_req low.
- R8: A read strobe returns data on rdata one cycle later. Bits 31:24 of rdata always read as zero. rdata holds its value when no read is issued.
- R9: A tick occurs every CLK_HZ/TICK_HZ clock cycles. The prescaler runs freely from the release of reset and is not restarted by writes.
- R10: After reset the timer is disarmed, the counter is 0, the control word is 0, rdata is 0 and reset_req is low.
- R11: In a cycle that carries an accepted write, the countdown does not advance, even if a tick falls in that cycle.
- R12: Reset asserts asynchronously. The internal logic leaves reset on the second rising clock edge after rst_n goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | DATA_W | Write data, with the key in bits 31:24 |
| rdata | output | DATA_W | Read data, valid the cycle after rd_en |
| reset_req | output | 1 | One-cycle chip-reset request |

## Verification
Read data is due one clock edge after the read strobe is sampled. A counter or control change caused by a write is therefore seen on rdata two edges after the write is sampled: one edge for the write and one for the read. reset_req rises on the edge after the edge where the expiring tick was taken. The bench's behavioural model advances on every rising edge, and the design's outputs are compared against it at every falling edge, so each result is checked in exactly the cycle in which it is due. The directed checks issue their reads exactly one prescaler period apart. This makes the step seen between two counter readings exactly one tick.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam logic [7:0] WDG_KEY       = 8'h5A;
  localparam int         WDG_KEY_W     = 8;
  localparam logic [7:0] WDG_OFF_CTRL  = 8'h1C;
  localparam logic [7:0] WDG_OFF_COUNT = 8'h24;
  localparam int         WDG_CFG_LSB   = 4;

  typedef enum logic [1:0] {
    CFG_NONE  = 2'b00,
    CFG_RSV_A = 2'b01,
    CFG_FULL  = 2'b10,
    CFG_RSV_B = 2'b11
  } wdg_cfg_e;
endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_passthru
      assign tick = 1'b1;
    end else begin : g_divide
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] div_q, div_d;
      logic          wrap;

      always_comb begin
        wrap  = (div_q == LAST);
        div_d = wrap ? '0 : div_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
      end

      assign tick = wrap;
    end
  endgenerate
endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              expire,
  input  logic [CNT_W-1:0]  cnt_q,
  output logic              ctrl_wr,
  output logic              cnt_wr,
  output logic              any_wr,
  output logic              armed,
  output logic [DATA_W-1:0] rdata
);
  localparam int CTRL_W = DATA_W - WDG_KEY_W;
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(WDG_OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(WDG_OFF_COUNT);

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              key_ok, hit_ctrl, hit_cnt;

  always_comb begin
    key_ok   = (wdata[DATA_W-1 -: WDG_KEY_W] == WDG_KEY);
    hit_ctrl = (addr == A_CTRL);
    hit_cnt  = (addr == A_COUNT);
    ctrl_wr  = wr_en && key_ok && hit_ctrl;
    cnt_wr   = wr_en && key_ok && hit_cnt;
    any_wr   = ctrl_wr || cnt_wr;
    armed    = (wdg_cfg_e'(ctrl_q[WDG_CFG_LSB +: 2]) == CFG_FULL);
  end

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr)
      ctrl_d = wdata[CTRL_W-1:0];
    else if (expire)
      ctrl_d[WDG_CFG_LSB +: 2] = CFG_NONE;
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_en) begin
      if (hit_ctrl)     rdata_d = {{WDG_KEY_W{1'b0}}, ctrl_q};
      else if (hit_cnt) rdata_d = DATA_W'(cnt_q);
      else              rdata_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      rdata_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/wdg_countdown.sv
module wdg_countdown #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             armed,
  input  logic             cnt_wr,
  input  logic             any_wr,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d  = cnt_q;
    expire = 1'b0;
    if (cnt_wr) begin
      cnt_d = load_val;
    end else if (!any_wr && tick && armed) begin
      if (cnt_q <= CNT_W'(1)) begin
        cnt_d  = '0;
        expire = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wdg_reset_ctrl.sv
module wdg_reset_ctrl #(
  parameter int CLK_HZ  = 250_000_000,
  parameter int TICK_HZ = 65536,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              reset_req
);
  localparam int RATIO = CLK_HZ / TICK_HZ;
  localparam int DIV   = (RATIO < 1) ? 1 : RATIO;

  logic             rst_meta_q, rst_sync_n;
  logic             tick, expire, armed;
  logic             ctrl_wr, cnt_wr, any_wr;
  logic [CNT_W-1:0] cnt_q;
  logic             reset_req_q;

  // Asynchronous assert, two-stage synchronous release (R12)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  wdg_prescaler #(.DIV(DIV)) u_presc (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .tick  (tick)
  );

  wdg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .expire  (expire),
    .cnt_q   (cnt_q),
    .ctrl_wr (ctrl_wr),
    .cnt_wr  (cnt_wr),
    .any_wr  (any_wr),
    .armed   (armed),
    .rdata   (rdata)
  );

  wdg_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick     (tick),
    .armed    (armed),
    .cnt_wr   (cnt_wr),
    .any_wr   (any_wr),
    .load_val (wdata[CNT_W-1:0]),
    .cnt_q    (cnt_q),
    .expire   (expire)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) reset_req_q <= 1'b0;
    else             reset_req_q <= expire;
  end

  assign reset_req = reset_req_q;
endmodule

// File: rtl/wdg_reset_ctrl_chk.sv
module wdg_reset_ctrl_chk #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 20
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wdata,
  input logic              armed,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              reset_req,
  input logic [DATA_W-1:0] rdata
);
  logic key_wr;
  assign key_wr = wr_en && (wdata[DATA_W-1 -: 8] == 8'h5A);

  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reset_req |=> !reset_req);

  assert_req_needs_arm_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reset_req |-> $past(armed));

  assert_disarm_on_expiry_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reset_req |-> (!armed && cnt_q == '0));

  assert_bad_key_ignored_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && !key_wr && !armed) |=> ($stable(cnt_q) && !armed));

  assert_unarmed_hold_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!armed && !key_wr) |=> $stable(cnt_q));

  assert_no_count_rise_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !key_wr |=> (cnt_q <= $past(cnt_q)));

  assert_rdata_key_zero_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rdata[DATA_W-1 -: 8] == 8'h00);
endmodule

bind wdg_reset_ctrl wdg_reset_ctrl_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .wr_en      (wr_en),
  .wdata      (wdata),
  .armed      (armed),
  .cnt_q      (cnt_q),
  .reset_req  (reset_req),
  .rdata      (rdata)
);

// File: tb/tb_wdg_reset_ctrl.sv
`timescale 1ns/1ps
module tb_wdg_reset_ctrl;
  localparam int DIV    = 4;
  localparam int CLK_HZ = 65536 * DIV;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        reset_req;

  int compared = 0;
  int mismatched = 0;
  int pulses = 0;
  bit done = 0;
  bit live = 0;

  always #2 clk = ~clk;

  wdg_reset_ctrl #(.CLK_HZ(CLK_HZ)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .reset_req(reset_req)
  );

  // Behavioural reference model
  bit          m_s1, m_s2;
  int          m_presc;
  int          m_cnt;
  logic [23:0] m_ctrl;
  logic [31:0] m_rdata;
  bit          m_req;

  task automatic m_clear();
    m_presc = 0; m_cnt = 0; m_ctrl = '0; m_rdata = '0; m_req = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_clear();
    end else begin
      if (!m_s2) m_clear();
      else begin
        bit acc, tk;
        acc = wr_en && wdata[31:24] == 8'h5A && (addr == 8'h1C || addr == 8'h24);
        tk  = (m_presc == DIV - 1);
        m_presc = tk ? 0 : m_presc + 1;
        if (rd_en)
          m_rdata = (addr == 8'h1C) ? {8'h00, m_ctrl} :
                    (addr == 8'h24) ? m_cnt : 32'h0;
        m_req = 0;
        if (acc) begin
          if (addr == 8'h24) m_cnt = int'(wdata[19:0]);
          else               m_ctrl = wdata[23:0];
        end else if (tk && m_ctrl[5:4] == 2'b10) begin
          if (m_cnt <= 1) begin
            m_cnt = 0; m_ctrl[5:4] = 2'b00; m_req = 1;
          end else m_cnt = m_cnt - 1;
        end
      end
      m_s2 = m_s1; m_s1 = 1;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model (R5 R11 R12 on reset_req, R8 R9 on rdata)
  always @(negedge clk) begin
    if (live && !done) begin
      check("R5 R11 R12 reset_req vs model", {31'b0, reset_req}, {31'b0, m_req});
      check("R8 R9 R12 rdata vs model", rdata, m_rdata);
      if (reset_req) pulses++;
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; wdata = '0;
  endtask

  task automatic rd_raw(logic [7:0] a, output logic [31:0] v);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; v = rdata;
  endtask

  task automatic rd_chk(logic [7:0] a, logic [31:0] exp, string tag);
    logic [31:0] v;
    rd_raw(a, v);
    check(tag, v, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] v1, v2;
    rst_n = 0; wr_en = 0; rd_en = 0; addr = '0; wdata = '0;
    live = 1;
    idle(3);
    rst_n = 1;
    idle(5);
    // R10 reset state
    check("R10 reset_req after reset", {31'b0, reset_req}, 32'h0);
    check("R10 rdata after reset", rdata, 32'h0);
    rd_chk(8'h1C, 32'h0, "R10 ctrl after reset");
    rd_chk(8'h24, 32'h0, "R10 count after reset");
    // R2 wrong key
    wr(8'h24, 32'h12000005);
    rd_chk(8'h24, 32'h0, "R2 count after bad key");
    // R3 load and width
    wr(8'h24, 32'h5A000005);
    rd_chk(8'h24, 32'h5, "R3 count load");
    wr(8'h24, 32'h5AFFFFFF);
    rd_chk(8'h24, 32'h000FFFFF, "R3 count truncated to 20 bits");
    // R4 unarmed holds, reserved cfg holds
    idle(40);
    rd_chk(8'h24, 32'h000FFFFF, "R4 no decrement when unarmed");
    wr(8'h1C, 32'h5A000010);
    idle(40);
    rd_chk(8'h24, 32'h000FFFFF, "R4 no decrement with cfg 01");
    rd_chk(8'h1C, 32'h00000010, "R4 ctrl stored, key reads zero R8");
    // R1 unmapped address
    wr(8'h30, 32'h5A000020);
    rd_chk(8'h1C, 32'h00000010, "R1 ctrl unchanged by unmapped write");
    rd_chk(8'h30, 32'h0, "R1 unmapped read is zero");
    // R5 expiry with other ctrl bits kept
    pulses = 0;
    wr(8'h24, 32'h5A00000A);
    wr(8'h1C, 32'h5A0012A0);
    idle(60);
    check("R5 one pulse after 10 ticks", pulses, 1);
    rd_chk(8'h24, 32'h0, "R5 count zero after expiry");
    rd_chk(8'h1C, 32'h00001280, "R5 cfg cleared, other bits kept");
    // R5 corner: armed with zero count
    wr(8'h24, 32'h5A000000);
    wr(8'h1C, 32'h5A000020);
    idle(10);
    check("R5 zero count expires on next tick", pulses, 2);
    // R9 one tick per DIV cycles
    wr(8'h24, 32'h5A000400);
    wr(8'h1C, 32'h5A000020);
    rd_raw(8'h24, v1);
    idle(DIV - 2);
    rd_raw(8'h24, v2);
    check("R9 exactly one tick per prescaler period", v1 - v2, 32'h1);
    // R6 stop
    wr(8'h1C, 32'h5A000102);
    rd_raw(8'h24, v1);
    idle(500);
    rd_chk(8'h24, v1, "R6 count frozen after stop");
    check("R6 no pulse after stop", pulses, 2);
    rd_chk(8'h1C, 32'h00000102, "R6 stop value stored");
    // R2 bad key cannot stop a running timer
    wr(8'h24, 32'h5A000014);
    wr(8'h1C, 32'h5A000020);
    wr(8'h1C, 32'h00000102);
    idle(100);
    check("R2 bad-key stop ignored, timer expired", pulses, 3);
    // R7 kick, R11 writes hold the countdown
    wr(8'h24, 32'h5A000014);
    wr(8'h1C, 32'h5A000020);
    for (int i = 0; i < 6; i++) begin
      idle(50);
      wr(8'h24, 32'h5A000014);
    end
    check("R7 kicks prevent reset", pulses, 3);
    idle(100);
    check("R7 expiry after kicks stop", pulses, 4);
    idle(4);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule